// File: doc/BRIEF.md
# Pulse-Swallow Programmable Feedback Divider

This block is the feedback divider of an integer-N frequency synthesizer. It divides its input clock by N = P·B + A and gives one single-cycle pulse per N input cycles, which a phase comparator can use. Inside it, a dual-modulus prescaler divides by P+1 for the first A prescaler cycles of each period and by P for the remaining B−A cycles. So A·(P+1) + (B−A)·P = P·B + A.

The prescaler value, the B count and the A count are presented on plain inputs. Legal settings are taken into shadow registers only when a division period ends, so a change never shortens or stretches the period in progress. Illegal settings raise a flag and are refused: a running divider keeps its last legal setting, and a divider that is idle after reset stays idle. A second flag warns when the presented N lies below P²−P, the point under which not every integer N can be reached.

Top module: `pswallow_divider`

## Requirements
- R1: Once running, consecutive output pulses are exactly N = P·B + A input cycles apart, for the setting loaded at the start of that period.
- R2: The 2-bit prescaler select maps code 0 to P=8, 1 to P=16, 2 to P=32 and 3 to P=64 (P = 8 shifted left by the code).
- R3: `cfg_bad` is high, combinationally from the inputs, exactly when B < 3 or A > B. B spans 13 bits and A spans 6 bits.
- R4: An illegal setting is never loaded. While running, a period that ends with an illegal setting presented is followed by a period that reuses the previous legal setting. While idle, no pulse is produced.
- R5: Inputs are sampled only on the clock edge that ends a period. A change made in the middle of a period leaves that period's length unchanged and takes effect in the next period.
- R6: `div_pulse` is high for exactly one input cycle, on the last cycle of each period.
- R7: While `rst_n` is low, `div_pulse` is low and the divider is idle. The first rising edge with `rst_n` high and a legal setting presented loads that setting, and the first pulse appears N cycles after that edge.
- R8: `below_floor` is high, combinationally, exactly when the presented P·B + A is less than P²−P. For example, with P=16 the value N=239 is flagged and N=240 is not.
- R9: With select code 2, B=4875 and A=20, pulses are 156020 input cycles apart.
- R10: The extremes A=0 (pure divide by P·B) and A=B (pure divide by (P+1)·B) are both divided correctly, including the smallest legal B=3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Synchronous active-low reset |
| psel | input | 2 | Prescaler select, P = 8 << psel |
| b_val | input | 13 | Programmable B count |
| a_val | input | 6 | Swallow A count |
| div_pulse | output | 1 | One-cycle pulse on the last cycle of each period |
| cfg_bad | output | 1 | Presented setting is illegal (B < 3 or A > B) |
| below_floor | output | 1 | Presented N is below P²−P |

## Verification
Two events can land on the same edge: the end of a period, which reloads the counters, and a change of settings, which may be legal or illegal. The bench changes settings on the exact cycle of a pulse, so that the reloading edge sees the new values. It also changes them a few cycles into a period. For both cases it compares the measured gap between pulses with a value that a bench function computes: the new N, the old N, or the previous legal N when the new setting is illegal.

// File: rtl/pswd_pkg.sv
// Package: shared widths and the prescaler decode for the pulse-swallow divider.
// Assumes P is always a power of two starting at P_BASE.
package pswd_pkg;
    localparam int PSEL_W = 2;
    localparam int B_W    = 13;
    localparam int A_W    = 6;
    localparam int PC_W   = 7;   // holds P up to 64
    localparam int N_W    = 21;  // holds P*B+A with margin
    localparam int B_MIN  = 3;
    localparam int P_BASE = 8;

    // Decode the select code into the prescaler modulus P.
    function automatic logic [PC_W-1:0] p_of(input logic [PSEL_W-1:0] s);
        return PC_W'(P_BASE) << s;
    endfunction
endpackage

// File: rtl/pswd_cfg_check.sv
// Module: legality and gap-free-range checks on a presented setting.
// Purely combinational. Assumes P = 8 << psel.
module pswd_cfg_check
    import pswd_pkg::*;
(
    input  logic [PSEL_W-1:0] psel,
    input  logic [B_W-1:0]    b_val,
    input  logic [A_W-1:0]    a_val,
    output logic              bad,
    output logic              low_n
);
    logic [PC_W-1:0] p_w;
    logic [N_W-1:0]  n_w;
    logic [N_W-1:0]  floor_w;

    // Evaluate the legality rules and the contiguity floor.
    always_comb begin
        p_w     = p_of(psel);
        n_w     = N_W'(p_w) * N_W'(b_val) + N_W'(a_val);
        floor_w = N_W'(p_w) * N_W'(p_w) - N_W'(p_w);
        bad     = (b_val < B_W'(B_MIN)) || (B_W'(a_val) > b_val);
        low_n   = n_w < floor_w;
    end
endmodule

// File: rtl/pswd_prescaler.sv
// Module: dual-modulus prescaler, divides by P or P+1.
// It counts down to zero; every cycle at zero ends one prescaler cycle, and the
// counter then reloads for the modulus picked by hi_next.
// Assumes p_val >= 2.
module pswd_prescaler
    import pswd_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            load,
    input  logic            hi_next,
    input  logic [PC_W-1:0] p_val,
    output logic            tick
);
    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] reload_v;

    assign tick     = (pc_q == '0);
    assign reload_v = hi_next ? p_val : p_val - PC_W'(1);

    // Count modulus cycles and reload at each wrap or forced load.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pc_q <= '0;
        else if (load || (run && tick))
            pc_q <= reload_v;
        else if (run)
            pc_q <= pc_q - PC_W'(1);
    end
endmodule

// File: rtl/pswd_counters.sv
// Module: the B (programmable) and A (swallow) counters.
// Both step once per prescaler cycle. A stops at zero; the prescaler uses P+1
// while A is non-zero. Assumes A <= B when loaded.
module pswd_counters
    import pswd_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic           load,
    input  logic           tick,
    input  logic [B_W-1:0] b_new,
    input  logic [A_W-1:0] a_new,
    output logic [B_W-1:0] b_cnt,
    output logic [A_W-1:0] a_cnt,
    output logic           b_last,
    output logic           a_gt1
);
    assign b_last = (b_cnt == B_W'(1));
    assign a_gt1  = (a_cnt > A_W'(1));

    // Load both counters together, or step them at a prescaler wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_cnt <= '0;
            a_cnt <= '0;
        end else if (load) begin
            b_cnt <= b_new;
            a_cnt <= a_new;
        end else if (run && tick) begin
            b_cnt <= b_cnt - B_W'(1);
            if (a_cnt != '0)
                a_cnt <= a_cnt - A_W'(1);
        end
    end
endmodule

// File: rtl/pswallow_divider.sv
// Module: top of the pulse-swallow divider, N = P*B + A.
// Holds the shadow setting and decides when to load it. Legal inputs are taken
// at the first edge after reset, and afterwards only at a period end; illegal
// inputs are refused. Assumes synchronous active-low reset.
module pswallow_divider
    import pswd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PSEL_W-1:0] psel,
    input  logic [B_W-1:0]    b_val,
    input  logic [A_W-1:0]    a_val,
    output logic              div_pulse,
    output logic              cfg_bad,
    output logic              below_floor
);
    logic              running;
    logic [PSEL_W-1:0] p_sh;
    logic [B_W-1:0]    b_sh;
    logic [A_W-1:0]    a_sh;
    logic [PSEL_W-1:0] p_src;
    logic [B_W-1:0]    b_src;
    logic [A_W-1:0]    a_src;
    logic              tick;
    logic              b_last;
    logic              a_gt1;
    logic [B_W-1:0]    b_cnt;
    logic [A_W-1:0]    a_cnt;
    logic              period_end;
    logic              load;
    logic              hi_next;
    logic              in_ok;

    pswd_cfg_check u_cfg (
        .psel  (psel),
        .b_val (b_val),
        .a_val (a_val),
        .bad   (cfg_bad),
        .low_n (below_floor)
    );

    assign in_ok = !cfg_bad;

    // Pick the setting for the next period: new if legal, otherwise the kept one.
    always_comb begin
        p_src      = in_ok ? psel  : p_sh;
        b_src      = in_ok ? b_val : b_sh;
        a_src      = in_ok ? a_val : a_sh;
        period_end = running && tick && b_last;
        load       = period_end || (!running && in_ok);
        hi_next    = load ? (a_src != '0) : a_gt1;
    end

    // Track whether a legal setting has started the divider.
    always_ff @(posedge clk) begin
        if (!rst_n)
            running <= 1'b0;
        else if (load)
            running <= 1'b1;
    end

    // Capture legal settings into the shadow registers at a load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_sh <= '0;
            b_sh <= '0;
            a_sh <= '0;
        end else if (load && in_ok) begin
            p_sh <= psel;
            b_sh <= b_val;
            a_sh <= a_val;
        end
    end

    pswd_prescaler u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (running),
        .load    (load),
        .hi_next (hi_next),
        .p_val   (p_of(load ? p_src : p_sh)),
        .tick    (tick)
    );

    pswd_counters u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (running),
        .load   (load),
        .tick   (tick),
        .b_new  (b_src),
        .a_new  (a_src),
        .b_cnt  (b_cnt),
        .a_cnt  (a_cnt),
        .b_last (b_last),
        .a_gt1  (a_gt1)
    );

    assign div_pulse = period_end;
endmodule

// File: rtl/pswd_checker.sv
// Module: assertion checker for pswallow_divider, attached by bind.
// It keeps its own cycle counter to measure each period against the shadow N.
module pswd_checker
    import pswd_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              running,
    input logic              div_pulse,
    input logic [PSEL_W-1:0] p_sh,
    input logic [B_W-1:0]    b_sh,
    input logic [A_W-1:0]    a_sh,
    input logic [B_W-1:0]    b_cnt,
    input logic [A_W-1:0]    a_cnt
);
    logic [N_W-1:0] cyc;
    logic [N_W-1:0] n_exp;

    // Expected period from the shadow setting.
    assign n_exp = N_W'(p_of(p_sh)) * N_W'(b_sh) + N_W'(a_sh);

    // Count cycles since the start of the current period.
    always_ff @(posedge clk) begin
        if (!rst_n || !running || div_pulse)
            cyc <= '0;
        else
            cyc <= cyc + N_W'(1);
    end

    AST_PERIOD_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |-> (cyc == n_exp - N_W'(1))); // R1
    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |=> !div_pulse); // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> !div_pulse); // R7
    AST_SHADOW_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (b_sh >= B_W'(B_MIN) && B_W'(a_sh) <= b_sh)); // R4
    AST_HOLD_MIDPERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !div_pulse) |=> $stable({p_sh, b_sh, a_sh})); // R5
    AST_SWALLOW_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (B_W'(a_cnt) <= b_cnt)); // R10
endmodule

bind pswallow_divider pswd_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .running   (running),
    .div_pulse (div_pulse),
    .p_sh      (p_sh),
    .b_sh      (b_sh),
    .a_sh      (a_sh),
    .b_cnt     (b_cnt),
    .a_cnt     (a_cnt)
);

// File: tb/tb_pswallow_divider.sv
module tb_pswallow_divider;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 199000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  psel = '0;
    logic [12:0] b_val = '0;
    logic [5:0]  a_val = '0;
    logic        div_pulse;
    logic        cfg_bad;
    logic        below_floor;
    int          n_checks = 0;
    int          n_fails = 0;
    int          cur_n = 0;

    pswallow_divider dut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .b_val(b_val), .a_val(a_val),
        .div_pulse(div_pulse), .cfg_bad(cfg_bad), .below_floor(below_floor)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int exp_n(input int s, input int b, input int a);
        return (8 << s) * b + a;
    endfunction
    function automatic bit exp_bad(input int b, input int a);
        return (b < 3) || (a > b);
    endfunction
    function automatic bit exp_low(input int s, input int b, input int a);
        int p = 8 << s;
        return exp_n(s, b, a) < p * p - p;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic apply(input int s, input int b, input int a);
        psel = 2'(s); b_val = 13'(b); a_val = 6'(a);
        #1;
        check(cfg_bad == exp_bad(b, a), "R3 cfg_bad", int'(cfg_bad), int'(exp_bad(b, a)));
        check(below_floor == exp_low(s, b, a), "R8 below_floor", int'(below_floor), int'(exp_low(s, b, a)));
    endtask

    // Count negedges until the next pulse; optionally change inputs at step chg.
    task automatic measure(input bit chk_w, input int chg, input int s, input int b,
                           input int a, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (n == 1 && chk_w)
                check(!div_pulse, "R6 pulse width", int'(div_pulse), 0);
            if (n == chg) apply(s, b, a);
        end while (!div_pulse && n < 200000);
    endtask

    initial begin
        int n;
        int seed;
        seed = $urandom(32'h5A17);
        // Reset state with an illegal setting presented.
        apply(0, 2, 0);
        repeat (4) @(negedge clk);
        check(!div_pulse, "R7 reset output", int'(div_pulse), 0);
        rst_n = 1'b1;
        n = 0;
        repeat (100) begin
            @(negedge clk);
            if (div_pulse) n++;
        end
        check(n == 0, "R4 idle with illegal setting", n, 0);
        // Worked example, loaded from idle.
        apply(2, 4875, 20);
        measure(1'b0, 0, 0, 0, 0, n);
        check(n == 156020, "R9 example period", n, 156020);
        check(n == exp_n(2, 4875, 20), "R7 first pulse after load", n, exp_n(2, 4875, 20));
        // Directed corners, each applied on the pulse cycle.
        apply(0, 3, 0);   measure(1'b1, 0, 0, 0, 0, n);
        check(n == 24, "R10 B=3 A=0", n, 24);
        apply(0, 3, 3);   measure(1'b1, 0, 0, 0, 0, n);
        check(n == 27, "R10 A=B", n, 27);
        apply(3, 63, 63); measure(1'b1, 0, 0, 0, 0, n);
        check(n == 4095, "R2 P=64", n, 4095);
        apply(1, 14, 3);  measure(1'b1, 0, 0, 0, 0, n);
        check(n == 227, "R2 P=16 low N", n, 227);
        apply(1, 15, 0);  measure(1'b1, 0, 0, 0, 0, n);
        check(n == 240, "R8 floor value", n, 240);
        apply(1, 20, 5);  measure(1'b1, 0, 0, 0, 0, n);
        check(n == 325, "R1 P=16", n, 325);
        // Mid-period change: current period keeps old N.
        measure(1'b1, 3, 0, 10, 2, n);
        check(n == 325, "R5 old period kept", n, 325);
        measure(1'b1, 0, 0, 0, 0, n);
        check(n == 82, "R5 new period", n, 82);
        // Illegal setting while running is refused.
        apply(0, 5, 20);
        measure(1'b1, 0, 0, 0, 0, n);
        check(n == 82, "R4 illegal refused", n, 82);
        measure(1'b1, 0, 0, 0, 0, n);
        check(n == 82, "R4 illegal refused again", n, 82);
        cur_n = 82;
        // Random settings, some illegal.
        for (int i = 0; i < 10; i++) begin
            int s = int'($urandom % 4);
            int b = 1 + int'($urandom % 40);
            int a = int'($urandom % 46);
            apply(s, b, a);
            if (!exp_bad(b, a)) cur_n = exp_n(s, b, a);
            measure(1'b1, 0, 0, 0, 0, n);
            check(n == cur_n, "R1 random period", n, cur_n);
        end
        // Reset in mid-run, then restart.
        apply(1, 20, 5);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) begin
            @(negedge clk);
            check(!div_pulse, "R7 output low in reset", int'(div_pulse), 0);
        end
        rst_n = 1'b1;
        measure(1'b0, 0, 0, 0, 0, n);
        check(n == 325, "R7 restart period", n, 325);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", WD_CYCLES, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule